// File: doc/BRIEF.md
# Voltage-regulator bus command frame encoder

This block assembles 32-bit command frames for a two-wire voltage-regulator management bus and seals each one with a 3-bit CRC. A requester presents a command kind (read, or write-with-commit), a group bit, a 4-bit data type, a 4-bit rail select and a 16-bit payload. Once the request is accepted, the finished frame sits in an output register and is offered to the serial bridge through a valid/ready handshake.

A separate input asks for the all-ones idle frame, which resynchronises the regulator and carries no CRC. A standalone combinational checker recomputes the CRC of any 32-bit word, such as a response captured by the bridge, and flags a mismatch in the same cycle.

Top module: `avs_frame_enc`

## Requirements
- R1: Every non-idle frame carries start code 01 in bits [31:30], command 11 for a read or 00 for a write in bits [29:28], and the group bit in bit [27].
- R2: The data type sits in bits [26:23] and the rail select in bits [22:19]. A read of type T on rail R equals 0x7007FFF8 | T<<23 | R<<19 with the CRC in bits [2:0]. A broadcast status read (type 1110, rail 1111) equals 0x777FFFF8 plus the CRC.
- R3: On a read, payload bits [18:3] are forced to all ones whatever the payload input holds. On a write they carry the payload, so a status-clear write with mask M equals 0x47780000 | M<<3 plus the CRC.
- R4: Bits [2:0] of a non-idle frame hold the remainder of bits [31:3] followed by three zero bits, divided by 1011 MSB first.
- R5: A request with the idle input high produces 0xFFFFFFFF, regardless of every other field and with no CRC inserted.
- R6: A request is accepted on a clock edge where request valid and request ready are both high. The frame is presented with frame valid high from the next cycle.
- R7: While frame valid is high and frame ready is low, the frame and frame valid hold unchanged.
- R8: Request ready is high whenever the output register is empty or is being drained in the same cycle, so an always-ready sink takes one frame per cycle.
- R9: The CRC checker raises its error output in the same cycle when bits [2:0] of the checked word differ from the remainder of its bits [31:3], and keeps it low otherwise.
- R10: After reset, frame valid is low and request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_read_i | input | 1 | 1 = read, 0 = write with commit |
| req_grp_i | input | 1 | Command group bit |
| req_dtype_i | input | 4 | Data type |
| req_rail_i | input | 4 | Rail select (1111 = all rails) |
| req_data_i | input | 16 | Command payload (writes only) |
| req_idle_i | input | 1 | Send the all-ones idle frame instead |
| frm_valid_o | output | 1 | Frame available |
| frm_ready_i | input | 1 | Bridge takes the frame |
| frm_o | output | 32 | Encoded frame |
| chk_word_i | input | 32 | Word whose CRC is checked |
| chk_err_o | output | 1 | CRC mismatch on chk_word_i |

## Verification
The hardest situation to reach is a new request arriving in the same cycle that a stalled frame is finally drained. Acceptance then depends on the sink's ready in that very cycle, and the held frame must neither change early nor be lost. The stimulus drives frame ready from a pseudo-random sequence while the driver keeps requests pending, so stalls of varying length end exactly as new requests wait. A phase with ready held high then confirms one acceptance per consecutive cycle.

// File: rtl/avs_frame_pkg.sv
package avs_frame_pkg;
  localparam int unsigned FRAME_W = 32;
  localparam int unsigned CRC_W   = 3;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned BODY_W  = FRAME_W - CRC_W;
  // x^3 + x + 1, leading term implied
  localparam logic [CRC_W-1:0] CRC_POLY = 3'b011;
  localparam logic [1:0] START_CODE = 2'b01;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'b00,
    CMD_READ  = 2'b11
  } avs_cmd_e;

  typedef struct packed {
    logic [1:0]        start;
    avs_cmd_e          cmd;
    logic              grp;
    logic [SEL_W-1:0]  dtype;
    logic [SEL_W-1:0]  rail;
    logic [DATA_W-1:0] data;
  } avs_body_t;
endpackage

// File: rtl/avs_crc3.sv
module avs_crc3 #(
  parameter int unsigned IN_W  = 29,
  parameter int unsigned CRC_W = 3,
  parameter logic [CRC_W-1:0] POLY = 3'b011
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [CRC_W-1:0] crc_o
);
  // serial division unrolled, MSB first, zero init
  always_comb begin
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = data_i[i] ^ r[CRC_W-1];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = r;
  end
endmodule

// File: rtl/avs_frame_pack.sv
module avs_frame_pack
  import avs_frame_pkg::*;
(
  input  logic              read_i,
  input  logic              grp_i,
  input  logic [SEL_W-1:0]  dtype_i,
  input  logic [SEL_W-1:0]  rail_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              idle_i,
  output logic [FRAME_W-1:0] frame_o
);
  avs_body_t body;
  logic [CRC_W-1:0] crc;

  always_comb begin
    body.start = START_CODE;
    body.cmd   = read_i ? CMD_READ : CMD_WRITE;
    body.grp   = grp_i;
    body.dtype = dtype_i;
    body.rail  = rail_i;
    body.data  = read_i ? '1 : data_i;  // reads carry an all-ones payload
  end

  avs_crc3 #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .data_i (body),
    .crc_o  (crc)
  );

  assign frame_o = idle_i ? '1 : {body, crc};
endmodule

// File: rtl/avs_frame_out.sv
module avs_frame_out #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         take;

  assign in_ready_o = !vld_q || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        dat_q <= in_data_i;
      end else if (out_ready_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
endmodule

// File: rtl/avs_crc_check.sv
module avs_crc_check
  import avs_frame_pkg::*;
(
  input  logic [FRAME_W-1:0] word_i,
  output logic               err_o
);
  logic [CRC_W-1:0] crc;

  avs_crc3 #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .data_i (word_i[FRAME_W-1:CRC_W]),
    .crc_o  (crc)
  );

  assign err_o = (crc != word_i[CRC_W-1:0]);
endmodule

// File: rtl/avs_frame_enc.sv
module avs_frame_enc
  import avs_frame_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_read_i,
  input  logic               req_grp_i,
  input  logic [SEL_W-1:0]   req_dtype_i,
  input  logic [SEL_W-1:0]   req_rail_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic               req_idle_i,
  output logic               frm_valid_o,
  input  logic               frm_ready_i,
  output logic [FRAME_W-1:0] frm_o,
  input  logic [FRAME_W-1:0] chk_word_i,
  output logic               chk_err_o
);
  logic [FRAME_W-1:0] frame_d;

  avs_frame_pack u_pack (
    .read_i  (req_read_i),
    .grp_i   (req_grp_i),
    .dtype_i (req_dtype_i),
    .rail_i  (req_rail_i),
    .data_i  (req_data_i),
    .idle_i  (req_idle_i),
    .frame_o (frame_d)
  );

  avs_frame_out #(.W(FRAME_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (frame_d),
    .out_valid_o (frm_valid_o),
    .out_ready_i (frm_ready_i),
    .out_data_o  (frm_o)
  );

  avs_crc_check u_chk (
    .word_i (chk_word_i),
    .err_o  (chk_err_o)
  );
endmodule

// File: rtl/avs_frame_enc_chk.sv
module avs_frame_enc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_idle_i,
  input logic        frm_valid_o,
  input logic        frm_ready_i,
  input logic [31:0] frm_o
);
  // R1
  start_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && (frm_o != 32'hFFFF_FFFF) |-> frm_o[31:30] == 2'b01);

  // R3
  read_payload_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && (frm_o[29:28] == 2'b11) |-> frm_o[18:3] == 16'hFFFF);

  // R5
  idle_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_idle_i |=> frm_o == 32'hFFFF_FFFF);

  // R6
  accept_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> frm_valid_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && !frm_ready_i |=> frm_valid_o && $stable(frm_o));

  // R8
  full_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && !frm_ready_i |-> !req_ready_o);
endmodule

bind avs_frame_enc avs_frame_enc_chk u_frame_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_idle_i  (req_idle_i),
  .frm_valid_o (frm_valid_o),
  .frm_ready_i (frm_ready_i),
  .frm_o       (frm_o)
);

// File: tb/avs_frame_enc_test.sv
module avs_frame_enc_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_read_i = 1'b0;
  logic        req_grp_i = 1'b0;
  logic [3:0]  req_dtype_i = '0;
  logic [3:0]  req_rail_i = '0;
  logic [15:0] req_data_i = '0;
  logic        req_idle_i = 1'b0;
  logic        frm_valid_o;
  logic        frm_ready_i = 1'b0;
  logic [31:0] frm_o;
  logic [31:0] chk_word_i = '0;
  logic        chk_err_o;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit always_ready = 1'b0;
  bit b2b = 1'b0;
  int last_acc = -10;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] prev_frm = '0;
  bit prev_stall = 1'b0;

  avs_frame_enc uut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [2:0] ref_crc(input logic [31:0] w);
    logic [31:0] r;
    r = w & 32'hFFFF_FFF8;
    for (int i = 31; i >= 3; i--)
      if (r[i]) r = r ^ (32'hB << (i - 3));
    return r[2:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic send(input logic rd, input logic grp, input logic [3:0] dt, input logic [3:0] rl,
                      input logic [15:0] dat, input logic idl, input logic [31:0] exp, input string tag);
    bit acc;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_read_i = rd; req_grp_i = grp; req_dtype_i = dt;
    req_rail_i = rl; req_data_i = dat; req_idle_i = idl;
    forever begin
      #4;
      acc = req_ready_o;
      if (acc) begin
        exp_q.push_back('{exp, tag});
        if (b2b && last_acc >= 0) check(cyc == last_acc + 1, "R8 back-to-back", cyc, last_acc + 1);
        last_acc = cyc;
      end
      @(posedge clk_i);
      if (acc) break;
      @(negedge clk_i);
    end
    #1 req_valid_i = 1'b0;
  endtask

  // monitor: drives sink ready, pops and compares at handshakes
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      frm_ready_i = always_ready ? 1'b1 : (rst_ni && lfsr[0]);
      #4;
      if (rst_ni) begin
        if (prev_stall) begin
          check(frm_valid_o && frm_o == prev_frm, "R7 hold", frm_o, prev_frm);
        end
        prev_stall = frm_valid_o && !frm_ready_i;
        prev_frm = frm_o;
        if (frm_valid_o && frm_ready_i) begin
          if (exp_q.size() == 0) check(1'b0, "R6 unexpected frame", frm_o, 32'h0);
          else begin
            e = exp_q.pop_front();
            check(frm_o === e.val, e.tag, frm_o, e.val);
          end
        end
      end
    end
  end

  function automatic logic [31:0] rd_frame(input logic [3:0] t, input logic [3:0] r);
    logic [31:0] w;
    w = 32'h7007_FFF8 | (32'(t) << 23) | (32'(r) << 19);
    return w | 32'(ref_crc(w));
  endfunction

  function automatic logic [31:0] wr_frame(input logic grp, input logic [3:0] t, input logic [3:0] r,
                                           input logic [15:0] d);
    logic [31:0] w;
    w = {2'b01, 2'b00, grp, t, r, d, 3'b000};
    return w | 32'(ref_crc(w));
  endfunction

  task automatic run_test();
    logic [31:0] w, sr, sc;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(frm_valid_o == 1'b0, "R10 valid low", 32'(frm_valid_o), 32'h0);
    check(req_ready_o == 1'b1, "R10 ready high", 32'(req_ready_o), 32'h1);
    rst_ni = 1'b1;

    sr = 32'h777F_FFF8 | 32'(ref_crc(32'h777F_FFF8));
    sc = 32'h4778_0000 | (32'h0012 << 3);
    sc = sc | 32'(ref_crc(sc));

    // random sink ready: stalls exercise R7
    send(1'b1, 1'b0, 4'd0, 4'd2, 16'h1234, 1'b0, rd_frame(4'd0, 4'd2), "R2 read voltage");
    send(1'b1, 1'b0, 4'd2, 4'd5, 16'h0000, 1'b0, rd_frame(4'd2, 4'd5), "R3 read payload forced");
    send(1'b1, 1'b0, 4'hE, 4'hF, 16'hABCD, 1'b0, sr, "R2 broadcast status read");
    send(1'b0, 1'b0, 4'hE, 4'hF, 16'h0012, 1'b0, sc, "R3 status clear write");
    send(1'b0, 1'b1, 4'h3, 4'h9, 16'hF00F, 1'b0, wr_frame(1'b1, 4'h3, 4'h9, 16'hF00F), "R1 write group bit");
    send(1'b1, 1'b1, 4'h7, 4'h1, 16'h5555, 1'b0, 32'h7007_FFF8 | 32'h0800_0000 | (32'h7 << 23) | (32'h1 << 19) | 32'(ref_crc(32'h7807_FFF8 | (32'h7 << 23) | (32'h1 << 19))), "R1 read group bit");
    send(1'b1, 1'b0, 4'h5, 4'h0, 16'h0, 1'b1, 32'hFFFF_FFFF, "R5 idle frame");
    send(1'b0, 1'b1, 4'hA, 4'h6, 16'h0001, 1'b1, 32'hFFFF_FFFF, "R5 idle ignores fields");
    for (int i = 0; i < 24; i++) begin
      w = wr_frame(1'b0, 4'(i), 4'(15 - i), 16'(i * 16'h0913));
      send(1'b0, 1'b0, 4'(i), 4'(15 - i), 16'(i * 16'h0913), 1'b0, w, "R4 write crc sweep");
    end
    for (int i = 0; i < 16; i++)
      send(1'b1, 1'b0, 4'(i), 4'(i), 16'h0, 1'b0, rd_frame(4'(i), 4'(i)), "R4 read crc sweep");

    // R8: sink always ready, one acceptance per cycle
    repeat (4) @(negedge clk_i);
    always_ready = 1'b1;
    repeat (2) @(negedge clk_i);
    b2b = 1'b1; last_acc = -10;
    for (int i = 0; i < 8; i++)
      send(1'b0, 1'b0, 4'h1, 4'(i), 16'(i), 1'b0, wr_frame(1'b0, 4'h1, 4'(i), 16'(i)), "R6 streamed write");
    b2b = 1'b0;
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R6 all frames delivered", 32'(exp_q.size()), 32'h0);

    // R9 checker
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      w = rd_frame(4'(i), 4'(i + 3));
      chk_word_i = w;
      #1 check(chk_err_o == 1'b0, "R9 good word", 32'(chk_err_o), 32'h0);
      chk_word_i = w ^ (32'h1 << (4 + i * 4));
      #1 check(chk_err_o == 1'b1, "R9 body bit flipped", 32'(chk_err_o), 32'h1);
      chk_word_i = w ^ 32'(1 << (i % 3));
      #1 check(chk_err_o == 1'b1, "R9 crc bit flipped", 32'(chk_err_o), 32'h1);
    end
  endtask

  initial begin
    fork
      run_test();
      begin
        repeat (100000) @(posedge clk_i);
        check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule